// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Pin-Control Instructions

This block is the test access port of a small device. A 16-state controller follows the TMS line on each TCK rising edge and steers serial data from TDI through either a 4-bit instruction register or a data register to TDO. The data register is either a one-bit bypass stage or a boundary chain that observes and overrides a parametric number of output pins. Each pin has an input-observe cell, an output-value cell and an output-enable cell. The value and enable cells have a hold stage behind them.

The active instruction decides three things: who drives the pins, whether a reset request goes to the system logic, and which data register sits between TDI and TDO. The choices for pin control are functional logic, the hold stage, or all drivers off. A handoff instruction passes the port through to a secondary debug TAP. The port stays handed off until the test reset input is asserted.

Top module: `jtag_pin_tap`

## Requirements
- R1: With rst_ni low (test reset), the controller enters Test-Logic-Reset and BYPASS becomes active. The handoff is cleared, pads follow func_do_i/func_oe_i, sys_rst_req_o is 0, tdo_en_o is 0 and sec_sel_o is 0.
- R2: When not handed off, five TCK rising edges with TMS high reach Test-Logic-Reset from any state. This makes BYPASS active, releases sys_rst_req_o and returns the pads to functional control.
- R3: The instruction register is 4 bits and shifts in LSB first. Capture-IR loads 0001, so the first bits shifted out are 1 then 0. A shifted opcode takes effect only when the controller passes through Update-IR.
- R4: Opcodes are EXTEST=0000, SAMPLE/PRELOAD=0001, HIGHZ=1001, CLAMP=1100, handoff=0111 and BYPASS=1111. Every other code acts as BYPASS.
- R5: BYPASS, HIGHZ, CLAMP and undefined codes select the one-bit bypass stage. It loads 0 on the rising edge in Capture-DR, so TDO carries 0 first and then TDI delayed by one shift.
- R6: EXTEST and SAMPLE/PRELOAD select a boundary chain of 3*N_PINS bits. For pin k, bit 3k holds pad_di_i[k], bit 3k+1 holds the output value and bit 3k+2 holds the output enable. Capture-DR loads pad_di_i, func_do_i and func_oe_i into these bits. Bit 0 is nearest TDO, and the first bit shifted in ends in bit 0. Update-DR copies the value and enable bits into the hold stage, which changes at no other time.
- R7: Under EXTEST, pad_do_o and pad_oe_o come from the hold stage and sys_rst_req_o is 0. Under SAMPLE/PRELOAD the pads stay functional.
- R8: Under CLAMP, pad_do_o and pad_oe_o come from the hold stage and sys_rst_req_o is 1.
- R9: Under HIGHZ, every bit of pad_oe_o is 0, pad_do_o follows func_do_i, and sys_rst_req_o is 1.
- R10: TDO and tdo_en_o change on the falling edge of TCK. tdo_en_o is 1 only while the controller is in Shift-IR or Shift-DR.
- R11: After Update-IR with opcode 0111, sec_sel_o is 1 and tdo_o/tdo_en_o follow sec_tdo_i/sec_tdo_en_i. sec_tms_o follows tms_i, and sec_tms_o is held at 1 when not handed off. The pads are functional and no reset request is made. Later instruction loads and TMS-high runs have no effect. Only rst_ni ends the handoff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Test reset, active low, asynchronous |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Test data in |
| tdo_o | output | 1 | Test data out |
| tdo_en_o | output | 1 | TDO driver enable |
| func_do_i | input | N_PINS | Functional output values from core logic |
| func_oe_i | input | N_PINS | Functional output enables from core logic |
| pad_di_i | input | N_PINS | Observed pad input levels |
| pad_do_o | output | N_PINS | Output value to pad drivers |
| pad_oe_o | output | N_PINS | Output enable to pad drivers |
| sys_rst_req_o | output | 1 | Internal system reset request |
| sec_sel_o | output | 1 | Port handed to secondary debug TAP |
| sec_tms_o | output | 1 | TMS toward secondary TAP |
| sec_tdi_o | output | 1 | TDI toward secondary TAP |
| sec_tdo_i | input | 1 | TDO from secondary TAP |
| sec_tdo_en_i | input | 1 | TDO enable from secondary TAP |

## Verification
Each defined opcode and three undefined codes are loaded in turn. For each one, the bench checks the pad values, the pad enables and the reset request against a hold stage preloaded with a pattern that differs from the functional inputs. This separates functional, hold-driven and tristated pin control. A full-length data scan then follows. It separates a one-bit bypass path (leading 0, then TDI delayed by one) from the boundary chain, whose captured bits come out in a known per-pin order. Directed sequences cover the following:
- the Capture-IR pattern;
- stopping before Update-IR;
- the falling-edge timing of TDO;
- the five-TMS reset run;
- the handoff, which ignores everything except the test reset.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;
  localparam int unsigned IR_W = 4;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [2:0] {
    I_EXTEST, I_SAMPLE, I_HIGHZ, I_CLAMP, I_HANDOFF, I_BYPASS
  } instr_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0001;
  localparam logic [IR_W-1:0] OP_HIGHZ   = 4'b1001;
  localparam logic [IR_W-1:0] OP_CLAMP   = 4'b1100;
  localparam logic [IR_W-1:0] OP_HANDOFF = 4'b0111;

  function automatic instr_e decode_op(input logic [IR_W-1:0] op);
    case (op)
      OP_EXTEST:  return I_EXTEST;
      OP_SAMPLE:  return I_SAMPLE;
      OP_HIGHZ:   return I_HIGHZ;
      OP_CLAMP:   return I_CLAMP;
      OP_HANDOFF: return I_HANDOFF;
      default:    return I_BYPASS;
    endcase
  endfunction
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o,
  output tap_state_e state_d_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    case (state_q)
      ST_TLR:    state_d = tms_i ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms_i ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms_i ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms_i ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms_i ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms_i ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms_i ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms_i ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms_i ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms_i ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_TLR;
    else         state_q <= state_d;
  end

  assign state_o   = state_q;
  assign state_d_o = state_d;

  // five TMS-high edges always land in Test-Logic-Reset
  p_five_tms_tlr_r2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (tms_i && $past(tms_i) && $past(tms_i, 2) && $past(tms_i, 3) && $past(tms_i, 4))
    |=> state_q == ST_TLR);
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import jtag_tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tdi_i,
  input  tap_state_e state_i,
  input  tap_state_e state_d_i,
  output logic       so_o,
  output instr_e     instr_o,
  output logic       handoff_o
);
  localparam logic [IR_W-1:0] CAP_PAT = {{(IR_W-2){1'b0}}, 2'b01};

  logic [IR_W-1:0] sr_q;
  instr_e          instr_q;
  logic            handoff_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q      <= '0;
      instr_q   <= I_BYPASS;
      handoff_q <= 1'b0;
    end else begin
      if (state_i == ST_CAP_IR)     sr_q <= CAP_PAT;
      else if (state_i == ST_SH_IR) sr_q <= {tdi_i, sr_q[IR_W-1:1]};
      // once handed off, the instruction is frozen until test reset
      if (!handoff_q) begin
        if (state_d_i == ST_TLR) begin
          instr_q <= I_BYPASS;
        end else if (state_i == ST_UPD_IR) begin
          instr_q <= decode_op(sr_q);
          if (decode_op(sr_q) == I_HANDOFF) handoff_q <= 1'b1;
        end
      end
    end
  end

  assign so_o      = sr_q[0];
  assign instr_o   = instr_q;
  assign handoff_o = handoff_q;

  p_instr_only_on_update_r3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i != ST_UPD_IR && state_d_i != ST_TLR) |=> $stable(instr_q));
  p_tlr_bypass_r1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == ST_TLR && !handoff_q) |-> instr_q == I_BYPASS);
  p_handoff_sticky_r11: assert property (@(posedge tck_i) disable iff (!rst_ni)
    handoff_q |=> handoff_q && $stable(instr_q));
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import jtag_tap_pkg::*;
#(
  parameter int unsigned N_PINS = 4
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tdi_i,
  input  tap_state_e        state_i,
  input  logic              sel_i,
  input  logic [N_PINS-1:0] pad_di_i,
  input  logic [N_PINS-1:0] func_do_i,
  input  logic [N_PINS-1:0] func_oe_i,
  output logic              so_o,
  output logic [N_PINS-1:0] hold_do_o,
  output logic [N_PINS-1:0] hold_oe_o
);
  localparam int unsigned LEN = 3 * N_PINS;

  logic [LEN-1:0]    cap_vec, sr_q;
  logic [N_PINS-1:0] sr_do, sr_oe, hold_do_q, hold_oe_q;

  for (genvar k = 0; k < N_PINS; k++) begin : g_cell
    assign cap_vec[3*k]   = pad_di_i[k];
    assign cap_vec[3*k+1] = func_do_i[k];
    assign cap_vec[3*k+2] = func_oe_i[k];
    assign sr_do[k]       = sr_q[3*k+1];
    assign sr_oe[k]       = sr_q[3*k+2];
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q      <= '0;
      hold_do_q <= '0;
      hold_oe_q <= '0;
    end else if (sel_i) begin
      case (state_i)
        ST_CAP_DR: sr_q <= cap_vec;
        ST_SH_DR:  sr_q <= {tdi_i, sr_q[LEN-1:1]};
        ST_UPD_DR: begin
          hold_do_q <= sr_do;
          hold_oe_q <= sr_oe;
        end
        default: ;
      endcase
    end
  end

  assign so_o      = sr_q[0];
  assign hold_do_o = hold_do_q;
  assign hold_oe_o = hold_oe_q;

  p_hold_only_on_update_r6: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i != ST_UPD_DR) |=> $stable(hold_do_q) && $stable(hold_oe_q));
endmodule

// File: rtl/jtag_pin_tap.sv
module jtag_pin_tap
  import jtag_tap_pkg::*;
#(
  parameter int unsigned N_PINS = 4
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tms_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  output logic              tdo_en_o,
  input  logic [N_PINS-1:0] func_do_i,
  input  logic [N_PINS-1:0] func_oe_i,
  input  logic [N_PINS-1:0] pad_di_i,
  output logic [N_PINS-1:0] pad_do_o,
  output logic [N_PINS-1:0] pad_oe_o,
  output logic              sys_rst_req_o,
  output logic              sec_sel_o,
  output logic              sec_tms_o,
  output logic              sec_tdi_o,
  input  logic              sec_tdo_i,
  input  logic              sec_tdo_en_i
);
  tap_state_e        state, state_d;
  instr_e            instr;
  logic              handoff, ir_so, bs_so, bs_sel, byp_q, ser, tdo_q, tdo_en_q;
  logic [N_PINS-1:0] hold_do, hold_oe;

  tap_fsm u_fsm (
    .tck_i, .rst_ni, .tms_i,
    .state_o(state), .state_d_o(state_d)
  );

  tap_ir u_ir (
    .tck_i, .rst_ni, .tdi_i,
    .state_i(state), .state_d_i(state_d),
    .so_o(ir_so), .instr_o(instr), .handoff_o(handoff)
  );

  assign bs_sel = (instr == I_EXTEST) || (instr == I_SAMPLE);

  bscan_chain #(.N_PINS(N_PINS)) u_bs (
    .tck_i, .rst_ni, .tdi_i,
    .state_i(state), .sel_i(bs_sel),
    .pad_di_i, .func_do_i, .func_oe_i,
    .so_o(bs_so), .hold_do_o(hold_do), .hold_oe_o(hold_oe)
  );

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                byp_q <= 1'b0;
    else if (state == ST_CAP_DR) byp_q <= 1'b0;
    else if (state == ST_SH_DR)  byp_q <= tdi_i;
  end

  assign ser = (state == ST_SH_IR) ? ir_so : (bs_sel ? bs_so : byp_q);

  // falling-edge retiming of the serial output
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q    <= 1'b0;
      tdo_en_q <= 1'b0;
    end else begin
      tdo_q    <= ser;
      tdo_en_q <= (state == ST_SH_IR) || (state == ST_SH_DR);
    end
  end

  always_comb begin
    pad_do_o      = func_do_i;
    pad_oe_o      = func_oe_i;
    sys_rst_req_o = 1'b0;
    if (!handoff) begin
      case (instr)
        I_EXTEST: begin
          pad_do_o = hold_do;
          pad_oe_o = hold_oe;
        end
        I_CLAMP: begin
          pad_do_o      = hold_do;
          pad_oe_o      = hold_oe;
          sys_rst_req_o = 1'b1;
        end
        I_HIGHZ: begin
          pad_oe_o      = '0;
          sys_rst_req_o = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign sec_sel_o = handoff;
  assign sec_tms_o = handoff ? tms_i : 1'b1;
  assign sec_tdi_o = tdi_i;
  assign tdo_o     = handoff ? sec_tdo_i    : tdo_q;
  assign tdo_en_o  = handoff ? sec_tdo_en_i : tdo_en_q;

  p_bypass_loads_zero_r5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state == ST_CAP_DR) |=> !byp_q);
  p_tdo_en_shift_only_r10: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!handoff && tdo_en_o) |-> (state == ST_SH_IR || state == ST_SH_DR));
  p_highz_drivers_off_r9: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (instr == I_HIGHZ && !handoff) |-> (pad_oe_o == '0 && sys_rst_req_o));
  p_clamp_reset_r8: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (instr == I_CLAMP && !handoff) |-> sys_rst_req_o && pad_oe_o == hold_oe);
  p_handoff_no_reset_r11: assert property (@(posedge tck_i) disable iff (!rst_ni)
    handoff |-> !sys_rst_req_o && pad_oe_o == func_oe_i);
endmodule

// File: tb/jtag_pin_tap_tb_top.sv
`timescale 1ns/1ps
module jtag_pin_tap_tb_top;
  localparam int N = 4;
  localparam int L = 3 * N;
  localparam int NV = 8;
  // {opcode[3:0], mode[1:0] (0 func, 1 hold, 2 highz), sys_rst, boundary_selected}
  localparam logic [7:0] VEC [NV] = '{
    8'b0000_01_0_1, 8'b0001_00_0_1, 8'b1001_10_1_0, 8'b1100_01_1_0,
    8'b1111_00_0_0, 8'b0101_00_0_0, 8'b1010_00_0_0, 8'b0011_00_0_0
  };
  localparam logic [N-1:0] F_DO = 4'b1010, F_OE = 4'b1100, P_DI = 4'b0110;
  localparam logic [N-1:0] H_DO = 4'b0011, H_OE = 4'b0101;

  logic tck = 1'b0, rst_ni = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_en, sys_rst, sec_sel, sec_tms, sec_tdi;
  logic sec_tdo = 1'b0, sec_tdo_en = 1'b0;
  logic [N-1:0] pad_do, pad_oe;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [L-1:0] pre_chain, cap_chain;

  always #2.5 tck = ~tck;

  jtag_pin_tap #(.N_PINS(N)) dut_i (
    .tck_i(tck), .rst_ni(rst_ni), .tms_i(tms), .tdi_i(tdi),
    .tdo_o(tdo), .tdo_en_o(tdo_en),
    .func_do_i(F_DO), .func_oe_i(F_OE), .pad_di_i(P_DI),
    .pad_do_o(pad_do), .pad_oe_o(pad_oe), .sys_rst_req_o(sys_rst),
    .sec_sel_o(sec_sel), .sec_tms_o(sec_tms), .sec_tdi_o(sec_tdi),
    .sec_tdo_i(sec_tdo), .sec_tdo_en_i(sec_tdo_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d, output logic o);
    tms = m; tdi = d; o = tdo;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic load_ir(input logic [3:0] op, output logic [3:0] rd);
    logic o;
    tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < 4; i++) tick(i == 3, op[i], rd[i]);
    tick(1, 0, o); tick(0, 0, o);
  endtask

  task automatic scan_dr(input logic [L-1:0] din, output logic [L-1:0] dout);
    logic o;
    tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < L; i++) tick(i == L - 1, din[i], dout[i]);
    tick(1, 0, o); tick(0, 0, o);
  endtask

  task automatic pins(input string tag, input logic [1:0] mode, input logic rst);
    logic [N-1:0] edo, eoe;
    edo = (mode == 2'd1) ? H_DO : F_DO;
    eoe = (mode == 2'd1) ? H_OE : (mode == 2'd2) ? '0 : F_OE;
    chk({tag, " pad_do"}, 32'(pad_do), 32'(edo));
    chk({tag, " pad_oe"}, 32'(pad_oe), 32'(eoe));
    chk({tag, " sys_rst"}, 32'(sys_rst), 32'(rst));
  endtask

  initial begin
    logic o;
    logic [3:0] rd;
    logic [L-1:0] dout;
    for (int k = 0; k < N; k++) begin
      pre_chain[3*k] = 1'b0; pre_chain[3*k+1] = H_DO[k]; pre_chain[3*k+2] = H_OE[k];
      cap_chain[3*k] = P_DI[k]; cap_chain[3*k+1] = F_DO[k]; cap_chain[3*k+2] = F_OE[k];
    end
    repeat (2) @(negedge tck);
    #1 rst_ni = 1'b1;
    // R1 reset state
    pins("R1 reset", 2'd0, 1'b0);
    chk("R1 tdo_en", 32'(tdo_en), 0);
    chk("R1 sec_sel", 32'(sec_sel), 0);
    tick(0, 0, o);
    chk("R11 sec_tms held high", 32'(sec_tms), 1);
    // R3 new instruction only after Update-IR (HIGHZ shifted)
    tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < 4; i++) tick(i == 3, 4'b1001 >> i, rd[i]);
    chk("R3 capture pattern", 32'(rd), 32'b0001);
    chk("R3 no effect in Exit1-IR", 32'(sys_rst), 0);
    tick(1, 0, o);
    chk("R3 no effect in Update-IR", 32'(sys_rst), 0);
    tick(0, 0, o);
    pins("R9 highz after update", 2'd2, 1'b1);
    // preload hold stage through SAMPLE/PRELOAD
    load_ir(4'b0001, rd);
    scan_dr(pre_chain, dout);
    chk("R6 sample capture", 32'(dout), 32'(cap_chain));
    pins("R7 sample keeps functional", 2'd0, 1'b0);
    // opcode table
    for (int v = 0; v < NV; v++) begin
      load_ir(VEC[v][7:4], rd);
      chk($sformatf("R3 capture op=%b", VEC[v][7:4]), 32'(rd), 32'b0001);
      pins($sformatf("R4 R7 R8 R9 op=%b", VEC[v][7:4]), VEC[v][3:2], VEC[v][1]);
      scan_dr(pre_chain, dout);
      if (VEC[v][0])
        chk($sformatf("R6 boundary op=%b", VEC[v][7:4]), 32'(dout), 32'(cap_chain));
      else
        chk($sformatf("R5 bypass op=%b", VEC[v][7:4]), 32'(dout), 32'({pre_chain[L-2:0], 1'b0}));
      pins($sformatf("R6 hold kept op=%b", VEC[v][7:4]), VEC[v][3:2], VEC[v][1]);
    end
    // R10 TDO timing, bypass active
    load_ir(4'b1111, rd);
    chk("R10 tdo_en idle", 32'(tdo_en), 0);
    tick(1, 0, o); tick(0, 0, o);
    chk("R10 tdo_en off in Capture-DR", 32'(tdo_en), 0);
    tick(0, 0, o);
    chk("R10 tdo_en in Shift-DR", 32'(tdo_en), 1);
    chk("R5 first bit zero", 32'(tdo), 0);
    tms = 0; tdi = 1;
    @(posedge tck); #1;
    chk("R10 tdo holds past rising edge", 32'(tdo), 0);
    @(negedge tck); #1;
    chk("R10 tdo moves on falling edge", 32'(tdo), 1);
    tick(1, 0, o);
    chk("R10 tdo_en off in Exit1-DR", 32'(tdo_en), 0);
    tick(1, 0, o); tick(0, 0, o);
    // R2 five TMS high from Shift-DR under CLAMP
    load_ir(4'b1100, rd);
    tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < 4; i++) tick(1, 0, o);
    chk("R2 still clamped after four", 32'(sys_rst), 1);
    tick(1, 0, o);
    pins("R2 five tms high", 2'd0, 1'b0);
    tick(0, 0, o);
    // R11 handoff
    load_ir(4'b0111, rd);
    chk("R11 sec_sel", 32'(sec_sel), 1);
    pins("R11 functional pins", 2'd0, 1'b0);
    sec_tdo = 1; sec_tdo_en = 1; tms = 0; #1;
    chk("R11 tdo pass", 32'({tdo, tdo_en, sec_tms}), 32'b110);
    sec_tdo = 0; tms = 1; #1;
    chk("R11 tdo follows", 32'({tdo, tdo_en, sec_tms}), 32'b011);
    for (int i = 0; i < 5; i++) tick(1, 0, o);
    chk("R11 tms run ignored", 32'(sec_sel), 1);
    tick(0, 0, o);
    load_ir(4'b1100, rd);
    chk("R11 clamp load ignored", 32'({sec_sel, sys_rst}), 32'b10);
    rst_ni = 0; #1;
    chk("R1 trst ends handoff", 32'({sec_sel, sys_rst, tdo_en}), 0);
    @(negedge tck); #1 rst_ni = 1;
    sec_tdo_en = 0;
    tick(0, 0, o);
    load_ir(4'b1001, rd);
    pins("R1 ir usable after trst", 2'd2, 1'b1);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge tck);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule